// File: doc/BRIEF.md
# Sparse-Space Bus Address Translator

This block sits between a host that reaches an expansion bus through a sparse address window and the master side of a 32-bit bus. The host does not signal transfer size or byte offset on separate strobes. The bus offset is carried in the host address, shifted up by five bits. That leaves the low host bits free, and two of them hold a length code. A register-held extension supplies the bus address bits that the shifted field cannot reach.

For each accepted host request, the block works out the length. It then forms a longword-aligned bus address and active-low byte enables, and moves write data onto the addressed lanes. Read data is pulled back from those lanes and zero-extended. A 64-bit host access becomes two consecutive longword bus cycles. A length code the block cannot serve gets an error response, and no bus cycle is started. Only one request is in flight at a time.

Top module: `sparse_xlate`

## Requirements
- R1: The bus address is {extension register (5 bits), host address bits [31:7], 2'b00}. Host bits [31:5] carry the 27-bit bus offset, so the two lowest bus address bits are always driven as zero.
- R2: Host bits [4:3] give the length: 00 = byte, 01 = 16-bit word, 11 = longword. Host bits [6:5] give the byte offset. bus_be_n is active low with bit i for byte lane i (lane i = bus data bits [8i+7:8i]). A byte access enables lane offset, a word access enables lanes offset and offset+1, and a longword access enables all four lanes.
- R3: For a byte write, req_wdata[7:0] is driven on lane offset and the other bus data bits are zero. For a word write, req_wdata[15:0] is driven starting at lane offset, with zeros elsewhere.
- R4: A byte read returns the addressed lane in rsp_rdata[7:0], and a word read returns two lanes in rsp_rdata[15:0]. All higher response bits are zero. A write response carries zero data.
- R5: A longword access ignores the byte offset. It enables all lanes, drives req_wdata[31:0] unchanged, and returns the full bus word.
- R6: A 64-bit request (req_quad = 1, length 11) issues two bus cycles. The second is at the first address + 4. Writes send req_wdata[31:0] first and req_wdata[63:32] second. Reads return {second bus word, first bus word}.
- R7: Length code 10, a word access at offset 3, and a 64-bit request whose length code is not 11 are all rejected. Each gets a response with rsp_err = 1 and no bus cycle.
- R8: The extension register resets to zero and is loaded by ext_we. A request uses the value held when the request is accepted. A load in the same cycle as acceptance, or during a transfer, affects only later requests.
- R9: req_ready is high only while idle. The response is a one-cycle rsp_valid pulse in the cycle after the final bus_ack, or in the cycle after acceptance for a rejected request. bus_req, bus_addr, bus_be_n and bus_wdata hold steady until bus_ack.
- R10: After reset, req_ready = 1, bus_req = 0 and rsp_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_quad | input | 1 | 64-bit access |
| req_addr | input | 32 | Sparse host address |
| req_wdata | input | 64 | Host write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | 64 | Read result |
| ext_we | input | 1 | Load extension register |
| ext_wdata | input | 5 | New extension value |
| bus_req | output | 1 | Bus cycle requested |
| bus_write | output | 1 | Bus cycle direction |
| bus_addr | output | 32 | Longword-aligned bus address |
| bus_be_n | output | 4 | Active-low byte enables |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Bus cycle complete |
| bus_rdata | input | 32 | Bus read data, valid with bus_ack |

## Verification
The vector table exercises each length code at several byte offsets, as both read and write. Each pattern separates the lane-steering and enable cases: byte at lanes 1 and 2, word at lanes 0, 1 and 2, and longword with a non-zero offset that must be ignored. The bus model returns distinct bytes in each lane and different words on the first and second cycle. This makes a wrong lane, a swapped 64-bit half, or a missing second cycle show up as a data mismatch. The offset field is also tested at its all-ones extreme to prove the split between the extension bits and the shifted bits. Directed tests then load the extension register from reset, in the acceptance cycle and during a transfer, and drive each of the three reject cases.

// File: rtl/sparse_xlate_pkg.sv
package sparse_xlate_pkg;

    typedef enum logic [1:0] {
        LEN_BYTE = 2'b00,
        LEN_WORD = 2'b01,
        LEN_RSVD = 2'b10,
        LEN_LONG = 2'b11
    } sx_len_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS1 = 2'd1,
        ST_BUS2 = 2'd2,
        ST_RESP = 2'd3
    } sx_state_e;

endpackage

// File: rtl/sx_decode.sv
module sx_decode
    import sparse_xlate_pkg::*;
#(
    parameter int HOST_AW = 32,
    parameter int SHIFT   = 5,
    parameter int LEN_LSB = 3,
    parameter int LANES   = 4,
    localparam int OFFW   = $clog2(LANES),
    localparam int OFS_W  = HOST_AW - SHIFT
) (
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               quad,
    output sx_len_e            len,
    output logic [OFFW-1:0]    off,
    output logic [OFS_W-1:0]   ofs,
    output logic [LANES-1:0]   be_n,
    output logic               bad
);

    logic [LANES-1:0] mask;
    logic             unused_lo;

    assign unused_lo = ^host_addr[LEN_LSB-1:0];
    assign len = sx_len_e'(host_addr[LEN_LSB+1:LEN_LSB]);
    assign off = host_addr[SHIFT+OFFW-1:SHIFT];
    assign ofs = host_addr[HOST_AW-1:SHIFT];

    always_comb begin
        case (len)
            LEN_BYTE: mask = LANES'(1) << off;
            LEN_WORD: mask = LANES'(3) << off;
            LEN_LONG: mask = '1;
            default:  mask = '0;
        endcase
        be_n = ~mask;
        bad  = (len == LEN_RSVD)
            || (len == LEN_WORD && off == OFFW'(LANES - 1))
            || (quad && len != LEN_LONG);
    end

endmodule

// File: rtl/sx_lane.sv
module sx_lane
    import sparse_xlate_pkg::*;
#(
    parameter int BUS_W = 32,
    localparam int LANES = BUS_W / 8,
    localparam int OFFW  = $clog2(LANES)
) (
    input  sx_len_e          wr_len,
    input  logic [OFFW-1:0]  wr_off,
    input  logic [BUS_W-1:0] wr_src,
    output logic [BUS_W-1:0] wr_bus,
    input  sx_len_e          rd_len,
    input  logic [OFFW-1:0]  rd_off,
    input  logic [BUS_W-1:0] rd_bus,
    output logic [BUS_W-1:0] rd_val
);

    logic [OFFW+2:0]  wr_sh;
    logic [OFFW+2:0]  rd_sh;
    logic [BUS_W-1:0] rd_tmp;

    assign wr_sh  = {wr_off, 3'b000};
    assign rd_sh  = {rd_off, 3'b000};
    assign rd_tmp = rd_bus >> rd_sh;

    always_comb begin
        case (wr_len)
            LEN_BYTE: wr_bus = {{(BUS_W-8){1'b0}},  wr_src[7:0]}  << wr_sh;
            LEN_WORD: wr_bus = {{(BUS_W-16){1'b0}}, wr_src[15:0]} << wr_sh;
            default:  wr_bus = wr_src;
        endcase
        case (rd_len)
            LEN_BYTE: rd_val = {{(BUS_W-8){1'b0}},  rd_tmp[7:0]};
            LEN_WORD: rd_val = {{(BUS_W-16){1'b0}}, rd_tmp[15:0]};
            default:  rd_val = rd_bus;
        endcase
    end

endmodule

// File: rtl/sparse_xlate.sv
module sparse_xlate
    import sparse_xlate_pkg::*;
#(
    parameter int HOST_AW = 32,
    parameter int BUS_W   = 32,
    parameter int SHIFT   = 5,
    parameter int LEN_LSB = 3,
    localparam int LANES  = BUS_W / 8,
    localparam int OFFW   = $clog2(LANES),
    localparam int OFS_W  = HOST_AW - SHIFT,
    localparam int EXT_W  = BUS_W - OFS_W,
    localparam int DW     = 2 * BUS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic               req_quad,
    input  logic [HOST_AW-1:0] req_addr,
    input  logic [DW-1:0]      req_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [DW-1:0]      rsp_rdata,
    input  logic               ext_we,
    input  logic [EXT_W-1:0]   ext_wdata,
    output logic               bus_req,
    output logic               bus_write,
    output logic [BUS_W-1:0]   bus_addr,
    output logic [LANES-1:0]   bus_be_n,
    output logic [BUS_W-1:0]   bus_wdata,
    input  logic               bus_ack,
    input  logic [BUS_W-1:0]   bus_rdata
);

    typedef struct packed {
        sx_state_e        st;
        logic [EXT_W-1:0] ext;
        logic [BUS_W-1:0] addr;
        logic [LANES-1:0] be_n;
        logic [BUS_W-1:0] wd;
        logic [BUS_W-1:0] wd_hi;
        logic             wr;
        logic             quad;
        sx_len_e          len;
        logic [OFFW-1:0]  off;
        logic [BUS_W-1:0] rd_lo;
        logic [DW-1:0]    rdata;
        logic             err;
    } sx_reg_t;

    sx_reg_t r_q, r_d;

    sx_len_e          dec_len;
    logic [OFFW-1:0]  dec_off;
    logic [OFS_W-1:0] dec_ofs;
    logic [LANES-1:0] dec_be_n;
    logic             dec_bad;
    logic [BUS_W-1:0] lane_wr;
    logic [BUS_W-1:0] lane_rd;

    sx_decode #(
        .HOST_AW (HOST_AW),
        .SHIFT   (SHIFT),
        .LEN_LSB (LEN_LSB),
        .LANES   (LANES)
    ) u_decode (
        .host_addr (req_addr),
        .quad      (req_quad),
        .len       (dec_len),
        .off       (dec_off),
        .ofs       (dec_ofs),
        .be_n      (dec_be_n),
        .bad       (dec_bad)
    );

    sx_lane #(
        .BUS_W (BUS_W)
    ) u_lane (
        .wr_len (dec_len),
        .wr_off (dec_off),
        .wr_src (req_wdata[BUS_W-1:0]),
        .wr_bus (lane_wr),
        .rd_len (r_q.len),
        .rd_off (r_q.off),
        .rd_bus (bus_rdata),
        .rd_val (lane_rd)
    );

    always_comb begin
        r_d = r_q;
        if (ext_we) r_d.ext = ext_wdata;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.wr    = req_write;
                    r_d.quad  = req_quad;
                    r_d.len   = dec_len;
                    r_d.off   = dec_off;
                    r_d.err   = dec_bad;
                    r_d.rdata = '0;
                    r_d.addr  = {r_q.ext, dec_ofs[OFS_W-1:OFFW], OFFW'(0)};
                    r_d.be_n  = dec_be_n;
                    r_d.wd    = lane_wr;
                    r_d.wd_hi = req_wdata[DW-1:BUS_W];
                    r_d.st    = dec_bad ? ST_RESP : ST_BUS1;
                end
            end
            ST_BUS1: begin
                if (bus_ack) begin
                    if (r_q.quad) begin
                        r_d.rd_lo = bus_rdata;
                        r_d.addr  = r_q.addr + BUS_W'(LANES);
                        r_d.wd    = r_q.wd_hi;
                        r_d.st    = ST_BUS2;
                    end else begin
                        r_d.rdata = r_q.wr ? '0 : {{BUS_W{1'b0}}, lane_rd};
                        r_d.st    = ST_RESP;
                    end
                end
            end
            ST_BUS2: begin
                if (bus_ack) begin
                    r_d.rdata = r_q.wr ? '0 : {bus_rdata, r_q.rd_lo};
                    r_d.st    = ST_RESP;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign rsp_valid = (r_q.st == ST_RESP);
    assign rsp_err   = r_q.err;
    assign rsp_rdata = r_q.rdata;
    assign bus_req   = (r_q.st == ST_BUS1) || (r_q.st == ST_BUS2);
    assign bus_write = r_q.wr;
    assign bus_addr  = r_q.addr;
    assign bus_be_n  = r_q.be_n;
    assign bus_wdata = r_q.wd;

    // R1
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_addr[OFFW-1:0] == '0);

    // R2
    lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ($countones(~bus_be_n) == 1 || $countones(~bus_be_n) == 2
                     || $countones(~bus_be_n) == LANES));

    // R9
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr)
                                && $stable(bus_be_n) && $stable(bus_wdata));

    // R9
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && (bus_req || rsp_valid)));

    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7
    reject_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> $past(req_valid && req_ready));

    // R6
    quad_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack && r_q.st == ST_BUS1 && r_q.quad
        |=> bus_req && bus_addr == $past(bus_addr) + BUS_W'(LANES));

endmodule

// File: tb/sparse_xlate_bench.sv
module sparse_xlate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_quad = 1'b0;
    logic [31:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [63:0] rsp_rdata;
    logic        ext_we = 1'b0;
    logic [4:0]  ext_wdata = '0;
    logic        bus_req;
    logic        bus_write;
    logic [31:0] bus_addr;
    logic [3:0]  bus_be_n;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    always #10 clk = ~clk;

    sparse_xlate u_sparse_xlate (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_quad(req_quad), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ext_we(ext_we), .ext_wdata(ext_wdata),
        .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_be_n(bus_be_n), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    localparam logic [31:0] RD0 = 32'hDDCC_BBAA;
    localparam logic [31:0] RD1 = 32'h4433_2211;

    int          n_run = 0;
    int          n_fail = 0;
    int          ncyc = 0;
    int          busy_viol = 0;
    logic [31:0] log_a [4];
    logic [3:0]  log_be [4];
    logic [31:0] log_wd [4];
    logic        log_wr [4];
    logic        got_err;
    logic [63:0] got_rd;

    // bus slave: one-cycle acknowledge, distinct data per cycle of a transfer
    always @(negedge clk) begin
        if (bus_req) begin
            if (ncyc < 4) begin
                log_a[ncyc]  = bus_addr;
                log_be[ncyc] = bus_be_n;
                log_wd[ncyc] = bus_wdata;
                log_wr[ncyc] = bus_write;
            end
            bus_rdata = (ncyc == 0) ? RD0 : RD1;
            bus_ack   = 1'b1;
            ncyc      = ncyc + 1;
        end else begin
            bus_ack   = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic wr, input logic quad, input logic [31:0] ha,
                         input logic [63:0] wd, input logic ld, input logic [4:0] ev);
        @(negedge clk);
        ncyc      = 0;
        req_valid = 1'b1;
        req_write = wr;
        req_quad  = quad;
        req_addr  = ha;
        req_wdata = wd;
        ext_we    = ld;
        ext_wdata = ev;
        @(negedge clk);
        req_valid = 1'b0;
        ext_we    = 1'b0;
    endtask

    task automatic wait_rsp();
        int guard = 0;
        while (!rsp_valid && guard < 50) begin
            if (req_ready) busy_viol++;
            @(negedge clk);
            guard++;
        end
        if (!rsp_valid) begin
            n_run++;
            n_fail++;
            $display("FAIL R9 response timeout actual 0 expected 1");
        end
        got_err = rsp_err;
        got_rd  = rsp_rdata;
    endtask

    task automatic load_ext(input logic [4:0] v);
        @(negedge clk);
        ext_we    = 1'b1;
        ext_wdata = v;
        @(negedge clk);
        ext_we    = 1'b0;
    endtask

    typedef struct packed {
        logic        wr;
        logic        quad;
        logic [31:0] ha;
        logic [63:0] wd;
        logic        err;
        logic [2:0]  ncyc;
        logic [31:0] a0;
        logic [3:0]  be0;
        logic [31:0] wd0;
        logic [31:0] a1;
        logic [31:0] wd1;
        logic [63:0] rd;
    } vec_t;

    // extension register = 5'h03 for all table entries
    localparam vec_t VECS [13] = '{
        // R2 R4: byte read, offset 2
        '{1'b0, 1'b0, 32'h0246_8AC0, 64'h0, 1'b0, 3'd1, 32'h1812_3454, 4'b1011, 32'h0, 32'h0, 32'h0, 64'hCC},
        // R2 R3: byte write, offset 1
        '{1'b1, 1'b0, 32'h0000_2020, 64'hAB, 1'b0, 3'd1, 32'h1800_0100, 4'b1101, 32'h0000_AB00, 32'h0, 32'h0, 64'h0},
        // R2 R4: word read, offset 2
        '{1'b0, 1'b0, 32'h0000_40C8, 64'h0, 1'b0, 3'd1, 32'h1800_0204, 4'b0011, 32'h0, 32'h0, 32'h0, 64'hDDCC},
        // R2 R3: word write, offset 0
        '{1'b1, 1'b0, 32'h0000_6008, 64'h1234, 1'b0, 3'd1, 32'h1800_0300, 4'b1100, 32'h0000_1234, 32'h0, 32'h0, 64'h0},
        // R2 R3: word write, offset 1
        '{1'b1, 1'b0, 32'h0000_6028, 64'h1234, 1'b0, 3'd1, 32'h1800_0300, 4'b1001, 32'h0012_3400, 32'h0, 32'h0, 64'h0},
        // R5: longword read, offset 3 ignored
        '{1'b0, 1'b0, 32'h0000_8078, 64'h0, 1'b0, 3'd1, 32'h1800_0400, 4'b0000, 32'h0, 32'h0, 32'h0, 64'hDDCC_BBAA},
        // R5: longword write
        '{1'b1, 1'b0, 32'h0000_A018, 64'hCAFE_F00D, 1'b0, 3'd1, 32'h1800_0500, 4'b0000, 32'hCAFE_F00D, 32'h0, 32'h0, 64'h0},
        // R6: 64-bit read
        '{1'b0, 1'b1, 32'h0000_C018, 64'h0, 1'b0, 3'd2, 32'h1800_0600, 4'b0000, 32'h0, 32'h1800_0604, 32'h0, 64'h4433_2211_DDCC_BBAA},
        // R6: 64-bit write
        '{1'b1, 1'b1, 32'h0000_E018, 64'h1122_3344_5566_7788, 1'b0, 3'd2, 32'h1800_0700, 4'b0000, 32'h5566_7788, 32'h1800_0704, 32'h1122_3344, 64'h0},
        // R7: word at offset 3
        '{1'b0, 1'b0, 32'h0001_0068, 64'h0, 1'b1, 3'd0, 32'h0, 4'b0000, 32'h0, 32'h0, 32'h0, 64'h0},
        // R7: reserved length 10
        '{1'b1, 1'b0, 32'h0001_2010, 64'h55, 1'b1, 3'd0, 32'h0, 4'b0000, 32'h0, 32'h0, 32'h0, 64'h0},
        // R7: 64-bit with byte length
        '{1'b0, 1'b1, 32'h0001_4000, 64'h0, 1'b1, 3'd0, 32'h0, 4'b0000, 32'h0, 32'h0, 32'h0, 64'h0},
        // R1: all-ones offset field
        '{1'b0, 1'b0, 32'hFFFF_FF98, 64'h0, 1'b0, 3'd1, 32'h1FFF_FFFC, 4'b0000, 32'h0, 32'h0, 32'h0, 64'hDDCC_BBAA}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle state after reset
        chk("R10 req_ready", 64'(req_ready), 64'h1);
        chk("R10 bus_req", 64'(bus_req), 64'h0);
        chk("R10 rsp_valid", 64'(rsp_valid), 64'h0);

        // R8: extension register is zero after reset
        issue(1'b0, 1'b0, 32'h0000_0218, 64'h0, 1'b0, 5'h0);
        wait_rsp();
        chk("R8 reset ext addr", 64'(log_a[0]), 64'h0000_0010);

        load_ext(5'h03);
        foreach (VECS[i]) begin
            issue(VECS[i].wr, VECS[i].quad, VECS[i].ha, VECS[i].wd, 1'b0, 5'h0);
            wait_rsp();
            chk($sformatf("R7 vec%0d err", i), 64'(got_err), 64'(VECS[i].err));
            chk($sformatf("R7 vec%0d bus cycles", i), 64'(ncyc), 64'(VECS[i].ncyc));
            chk($sformatf("R4 R6 vec%0d rdata", i), got_rd, VECS[i].rd);
            if (VECS[i].ncyc != 0) begin
                chk($sformatf("R1 vec%0d addr", i), 64'(log_a[0]), 64'(VECS[i].a0));
                chk($sformatf("R2 vec%0d be_n", i), 64'(log_be[0]), 64'(VECS[i].be0));
                chk($sformatf("R3 vec%0d dir", i), 64'(log_wr[0]), 64'(VECS[i].wr));
                if (VECS[i].wr)
                    chk($sformatf("R3 vec%0d wdata", i), 64'(log_wd[0]), 64'(VECS[i].wd0));
            end
            if (VECS[i].ncyc == 2) begin
                chk($sformatf("R6 vec%0d addr2", i), 64'(log_a[1]), 64'(VECS[i].a1));
                chk($sformatf("R6 vec%0d be2", i), 64'(log_be[1]), 64'h0);
                if (VECS[i].wr)
                    chk($sformatf("R6 vec%0d wdata2", i), 64'(log_wd[1]), 64'(VECS[i].wd1));
            end
        end

        // R8: load during a 64-bit transfer does not touch it
        busy_viol = 0;
        @(negedge clk);
        ncyc      = 0;
        req_valid = 1'b1;
        req_write = 1'b0;
        req_quad  = 1'b1;
        req_addr  = 32'h0001_4018;
        @(negedge clk);
        req_valid = 1'b0;
        ext_we    = 1'b1;
        ext_wdata = 5'h1F;
        @(negedge clk);
        ext_we    = 1'b0;
        wait_rsp();
        chk("R8 inflight addr1", 64'(log_a[0]), 64'h1800_0A00);
        chk("R8 inflight addr2", 64'(log_a[1]), 64'h1800_0A04);
        // R9: ready stayed low across both bus cycles
        chk("R9 busy ready", 64'(busy_viol), 64'h0);

        // R8: new value used by the next request
        issue(1'b0, 1'b0, 32'h0001_6018, 64'h0, 1'b0, 5'h0);
        wait_rsp();
        chk("R8 next req addr", 64'(log_a[0]), 64'hF800_0B00);

        // R8: load in the acceptance cycle applies only afterwards
        issue(1'b0, 1'b0, 32'h0001_8018, 64'h0, 1'b1, 5'h01);
        wait_rsp();
        chk("R8 same-cycle addr", 64'(log_a[0]), 64'hF800_0C00);
        issue(1'b0, 1'b0, 32'h0001_A018, 64'h0, 1'b0, 5'h0);
        wait_rsp();
        chk("R8 after same-cycle addr", 64'(log_a[0]), 64'h0800_0D00);

        // R9: response is a single pulse, block returns to idle
        @(negedge clk);
        chk("R9 rsp pulse", 64'(rsp_valid), 64'h0);
        chk("R9 idle ready", 64'(req_ready), 64'h1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule